// File: doc/BRIEF.md
# Two-Channel Successive-Approximation Conversion Sequencer

This block is the digital control for a 5-bit successive-approximation converter that serves two analog inputs. A start request, taken while the block is idle, latches the requested channel, spends an opening stretch on sampling and then decides the code one bit per step. The MSB comes first. Each trial bit is kept only if the external comparator reports that the input is at or above the level the DAC presents. When the last bit is decided the code is stored in a result register and a completion flag rises. The DAC, the comparator and the analog multiplexer sit outside the block.

The whole conversion is paced from a slow reference clock to a fixed number of cycles. With the default of 96 cycles at 75 kHz this is 1.28 ms. The conversion cycles split into one sampling window and five equal bit steps. The block also holds a mode bit for each of the two shared pins, chosen independently. A mode bit of 0 keeps the pin a digital input and 1 hands it to the converter. A pin in analog mode reads back as logic low, because its digital buffer is off.

Top module: `sar5_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `result_o`, `dac_code_o` and `mode_o` are all zero.
- R2: A start request (`start_i`=1 at a rising edge while idle) raises `busy_o` from the next cycle for exactly CONV_CYCLES (96) cycles. `done_o` rises at the same edge at which `busy_o` falls.
- R3: `dac_code_o` is 0 while idle and during the first SAMPLE_CYC (16) busy cycles. During bit step k (k=0 for the MSB, each step STEP_CYC=16 cycles long) it shows the bits already decided, plus the trial bit at position 4-k set to 1.
- R4: A trial bit stays 1 only if `cmp_i` is 1 in the last cycle of its step. With an ideal comparator (`cmp_i` = input >= `dac_code_o`), the result is the input level in LSB units, rounded down and clamped to 00h..1Fh.
- R5: `result_o` loads the new code at the completion edge and holds it until the next completion.
- R6: `done_o` clears one edge after a `result_rd_i` pulse, and clears at the edge that accepts a new start. If completion and a read fall on the same edge, the flag ends up set.
- R7: A start request while `busy_o` is high is ignored. The conversion length, channel and result are unaffected.
- R8: `chan_sel_o` takes `chan_i` at the accepting edge and holds it for the whole conversion.
- R9: A `mode_wr_i` pulse loads `mode_i` into `mode_o` (bit n for pin n: 0 = digital, 1 = analog). `pin_rd_o[n]` follows `pin_i[n]` in digital mode and is 0 in analog mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for pacing |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request |
| chan_i | input | 1 | Channel requested with the start |
| cmp_i | input | 1 | Comparator: 1 when input >= DAC level |
| result_rd_i | input | 1 | Result read strobe, clears done |
| mode_wr_i | input | 1 | Load strobe for the pin modes |
| mode_i | input | 2 | New pin modes, 1 = analog |
| pin_i | input | 2 | Raw digital levels on the shared pins |
| dac_code_o | output | 5 | Trial code to the DAC |
| chan_sel_o | output | 1 | Channel driven to the analog multiplexer |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Result ready |
| result_o | output | 5 | Last conversion result |
| mode_o | output | 2 | Current pin modes |
| pin_rd_o | output | 2 | Digital read-back of the shared pins |

## Verification
The bench counts cycles from the edge that accepts a start. `busy_o` and the sampling-phase zero code are due in the very next cycle. Each bit step's DAC code is due at busy-cycle index 16+16k. The done flag and the result are due right after busy cycle 95. Read strobes and mode writes take effect one edge after they are driven. The pin read-back is combinational and is checked in the same cycle. All outputs are sampled on the falling edge, and each expected value is tied to the busy-cycle index the bench keeps itself, so every check lands in the cycle the requirement names.

// File: rtl/sar5_pkg.sv
package sar5_pkg;

  // Conversion phases seen by the pacing counter
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_BITS   = 2'd2
  } sar_phase_e;

  // Width for a counter that must hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sar5_rst_sync.sv
module sar5_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/sar5_pacer.sv
module sar5_pacer #(
  parameter int RES_BITS   = 5,
  parameter int SAMPLE_CYC = 16,
  parameter int STEP_CYC   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic run_i,
  output logic [sar5_pkg::cnt_width(RES_BITS)-1:0] step_o,
  output logic tick_o
);
  import sar5_pkg::*;

  localparam int MAX_LEN = (SAMPLE_CYC > STEP_CYC) ? SAMPLE_CYC : STEP_CYC;
  localparam int SUB_W   = cnt_width(MAX_LEN);
  localparam int PH_W    = cnt_width(RES_BITS);
  localparam logic [SUB_W-1:0] SAMPLE_END = SUB_W'(SAMPLE_CYC - 1);
  localparam logic [SUB_W-1:0] STEP_END   = SUB_W'(STEP_CYC - 1);

  logic [SUB_W-1:0] sub_q, sub_d;
  logic [PH_W-1:0]  step_q, step_d;
  logic             tick;
  logic             cnt_en;

  // Step 0 is the sampling window; steps 1..RES_BITS are bit decisions
  assign tick   = run_i && (sub_q == ((step_q == '0) ? SAMPLE_END : STEP_END));
  assign cnt_en = kick_i || run_i;

  always_comb begin
    sub_d  = sub_q;
    step_d = step_q;
    if (kick_i) begin
      sub_d  = '0;
      step_d = '0;
    end else if (tick) begin
      sub_d  = '0;
      step_d = step_q + 1'b1;
    end else begin
      sub_d  = sub_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= '0;
      step_q <= '0;
    end else if (cnt_en) begin
      sub_q  <= sub_d;
      step_q <= step_d;
    end
  end

  assign step_o = step_q;
  assign tick_o = tick;

endmodule

// File: rtl/sar5_core.sv
module sar5_core #(
  parameter int RES_BITS = 5,
  parameter int CH_W     = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [CH_W-1:0]     chan_i,
  input  logic                cmp_i,
  input  logic                rd_i,
  input  logic                tick_i,
  input  logic [sar5_pkg::cnt_width(RES_BITS)-1:0] step_i,
  output logic                kick_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [RES_BITS-1:0] dac_o,
  output logic [RES_BITS-1:0] result_o,
  output logic [CH_W-1:0]     chan_o,
  output sar5_pkg::sar_phase_e phase_o
);
  import sar5_pkg::*;

  localparam int PH_W = cnt_width(RES_BITS);
  localparam logic [PH_W-1:0] LAST_STEP = PH_W'(RES_BITS);

  logic                busy_q, busy_d;
  logic                done_q, done_d;
  logic [RES_BITS-1:0] sar_q, sar_d;
  logic [RES_BITS-1:0] res_q, res_d;
  logic [CH_W-1:0]     chan_q;
  logic [RES_BITS-1:0] trial;
  logic                kick;
  logic                decide;

  assign kick   = start_i && !busy_q;
  assign decide = busy_q && tick_i && (step_i != '0);

  // One-hot trial bit: step 1 tries the MSB, step RES_BITS the LSB
  generate
    for (genvar b = 0; b < RES_BITS; b++) begin : g_trial
      assign trial[b] = busy_q && (int'(step_i) == RES_BITS - b);
    end
  endgenerate

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    sar_d  = sar_q;
    res_d  = res_q;
    if (rd_i) begin
      done_d = 1'b0;
    end
    if (kick) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      sar_d  = '0;
    end else if (decide) begin
      for (int b = 0; b < RES_BITS; b++) begin
        if (trial[b]) begin
          sar_d[b] = cmp_i;
        end
      end
      if (step_i == LAST_STEP) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        res_d  = sar_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sar_q  <= '0;
      res_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      sar_q  <= sar_d;
      res_q  <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
    end else if (kick) begin
      chan_q <= chan_i;
    end
  end

  always_comb begin
    if (!busy_q)            phase_o = PH_IDLE;
    else if (step_i == '0)  phase_o = PH_SAMPLE;
    else                    phase_o = PH_BITS;
  end

  assign kick_o   = kick;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign dac_o    = busy_q ? (sar_q | trial) : '0;
  assign result_o = res_q;
  assign chan_o   = chan_q;

endmodule

// File: rtl/sar5_pinmux.sv
module sar5_pinmux #(
  parameter int PINS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [PINS-1:0] mode_i,
  input  logic [PINS-1:0] pin_i,
  output logic [PINS-1:0] mode_o,
  output logic [PINS-1:0] rd_o
);

  logic [PINS-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr_i) begin
      mode_q <= mode_i;
    end
  end

  // Analog-mode pins have their digital buffer off and read as low
  generate
    for (genvar p = 0; p < PINS; p++) begin : g_pin
      assign rd_o[p] = mode_q[p] ? 1'b0 : pin_i[p];
    end
  endgenerate

  assign mode_o = mode_q;

endmodule

// File: rtl/sar5_seq.sv
module sar5_seq #(
  parameter int RES_BITS    = 5,
  parameter int CHANNELS    = 2,
  parameter int CONV_CYCLES = 96,
  localparam int CH_W       = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [CH_W-1:0]     chan_i,
  input  logic                cmp_i,
  input  logic                result_rd_i,
  input  logic                mode_wr_i,
  input  logic [CHANNELS-1:0] mode_i,
  input  logic [CHANNELS-1:0] pin_i,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic [CH_W-1:0]     chan_sel_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [RES_BITS-1:0] result_o,
  output logic [CHANNELS-1:0] mode_o,
  output logic [CHANNELS-1:0] pin_rd_o
);
  import sar5_pkg::*;

  localparam int STEP_CYC   = CONV_CYCLES / (RES_BITS + 1);
  localparam int SAMPLE_CYC = CONV_CYCLES - RES_BITS * STEP_CYC;
  localparam int PH_W       = cnt_width(RES_BITS);

  logic            rst_int_n;
  logic            kick;
  logic            tick;
  logic [PH_W-1:0] step;
  sar_phase_e      phase;

  sar5_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  sar5_pacer #(
    .RES_BITS   (RES_BITS),
    .SAMPLE_CYC (SAMPLE_CYC),
    .STEP_CYC   (STEP_CYC)
  ) u_pacer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .kick_i (kick),
    .run_i  (busy_o),
    .step_o (step),
    .tick_o (tick)
  );

  sar5_core #(
    .RES_BITS (RES_BITS),
    .CH_W     (CH_W)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (start_i),
    .chan_i   (chan_i),
    .cmp_i    (cmp_i),
    .rd_i     (result_rd_i),
    .tick_i   (tick),
    .step_i   (step),
    .kick_o   (kick),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .dac_o    (dac_code_o),
    .result_o (result_o),
    .chan_o   (chan_sel_o),
    .phase_o  (phase)
  );

  sar5_pinmux #(
    .PINS (CHANNELS)
  ) u_pins (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_i   (mode_wr_i),
    .mode_i (mode_i),
    .pin_i  (pin_i),
    .mode_o (mode_o),
    .rd_o   (pin_rd_o)
  );

endmodule

// File: rtl/sar5_seq_chk.sv
module sar5_seq_chk #(
  parameter int RES_BITS    = 5,
  parameter int CHANNELS    = 2,
  parameter int CONV_CYCLES = 96,
  parameter int CH_W        = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                result_rd_i,
  input logic [RES_BITS-1:0] dac_code_o,
  input logic [CH_W-1:0]     chan_sel_o,
  input logic                busy_o,
  input logic                done_o,
  input logic [RES_BITS-1:0] result_o,
  input logic [CHANNELS-1:0] mode_o,
  input logic [CHANNELS-1:0] pin_rd_o
);

  localparam int BC_W = $clog2(CONV_CYCLES + 2);

  logic [BC_W-1:0] busy_cnt_q;
  logic [1:0]      since_rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt_q <= '0;
    end else if (busy_o) begin
      busy_cnt_q <= busy_cnt_q + 1'b1;
    end else begin
      busy_cnt_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst_q <= '0;
    end else if (since_rst_q != 2'd3) begin
      since_rst_q <= since_rst_q + 1'b1;
    end
  end

  // R2: an idle start after the reset-release window raises busy
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q >= 2'd2 && start_i && !busy_o) |=> busy_o);

  // R2: busy lasts exactly the configured number of cycles
  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_cnt_q == BC_W'(CONV_CYCLES)));

  // R2: completion flag comes with the end of busy
  p_done_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R3: no trial code is driven while idle
  p_dac_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (dac_code_o == '0));

  // R5: result holds while the flag stays up
  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o || $stable(result_o)));

  // R6: a read while idle clears the flag
  p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (result_rd_i && !busy_o) |=> !done_o);

  // R7: a running conversion cannot be cut short
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && busy_cnt_q != BC_W'(CONV_CYCLES - 1)) |=> busy_o);

  // R8: channel select stays fixed through a conversion
  p_chan_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (!busy_o || $stable(chan_sel_o)));

  // R9: analog-mode pins never read high
  p_pin_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_rd_o & mode_o) == '0));

endmodule

bind sar5_seq sar5_seq_chk #(
  .RES_BITS    (RES_BITS),
  .CHANNELS    (CHANNELS),
  .CONV_CYCLES (CONV_CYCLES),
  .CH_W        (CH_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .result_rd_i (result_rd_i),
  .dac_code_o  (dac_code_o),
  .chan_sel_o  (chan_sel_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .result_o    (result_o),
  .mode_o      (mode_o),
  .pin_rd_o    (pin_rd_o)
);

// File: tb/sar5_seq_test.sv
`timescale 1ns/1ps
module sar5_seq_test;

  localparam int CONV   = 96;
  localparam int SAMPLE = 16;
  localparam int STEP   = 16;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [0:0] chan_i;
  logic       cmp_i;
  logic       result_rd_i;
  logic       mode_wr_i;
  logic [1:0] mode_i;
  logic [1:0] pin_i;
  logic [4:0] dac_code_o;
  logic [0:0] chan_sel_o;
  logic       busy_o;
  logic       done_o;
  logic [4:0] result_o;
  logic [1:0] mode_o;
  logic [1:0] pin_rd_o;

  // Analog levels in quarter-LSB units, one per channel
  logic [7:0] vin0, vin1;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  sar5_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
    .cmp_i(cmp_i), .result_rd_i(result_rd_i), .mode_wr_i(mode_wr_i),
    .mode_i(mode_i), .pin_i(pin_i), .dac_code_o(dac_code_o),
    .chan_sel_o(chan_sel_o), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .mode_o(mode_o), .pin_rd_o(pin_rd_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Ideal comparator on the selected channel
  assign cmp_i = ((chan_sel_o[0] ? vin1 : vin0) >= {1'b0, dac_code_o, 2'b00});

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int v);
    int q = v / 4;
    return (q > 31) ? 31 : q;
  endfunction

  function automatic int exp_dac(input int code, input int c);
    int pos;
    int above;
    if (c < SAMPLE) return 0;
    pos   = 4 - (c - SAMPLE) / STEP;
    above = code & (~((1 << (pos + 1)) - 1)) & 31;
    return above | (1 << pos);
  endfunction

  // One conversion; optionally inject a start and a channel change mid-way
  task automatic convert(input int ch, input int v, input bit inject, input bit rd_at_end);
    int code;
    int busy_cnt;
    int dac_bad;
    int chan_bad;
    int prev_res;
    prev_res = int'(result_o);
    if (ch == 0) vin0 = 8'(v); else vin1 = 8'(v);
    code = exp_code(v);
    @(negedge clk);
    start_i = 1'b1;
    chan_i  = 1'(ch);
    @(negedge clk);
    start_i = 1'b0;
    chk("R6 done cleared by start", int'(done_o), 0);
    busy_cnt = 0; dac_bad = 0; chan_bad = 0;
    for (int c = 0; c < CONV + 8; c++) begin
      if (!busy_o) break;
      busy_cnt++;
      if (int'(dac_code_o) != exp_dac(code, c)) begin
        if (dac_bad == 0)
          $display("FAIL R3 cycle %0d actual=%0d expected=%0d", c, dac_code_o, exp_dac(code, c));
        dac_bad++;
      end
      if (int'(chan_sel_o) != ch) chan_bad++;
      if (c == CONV - 1) chk("R5 result held during run", int'(result_o), prev_res);
      if (inject && c == 40) begin
        start_i = 1'b1;
        chan_i  = 1'(~ch);
      end else begin
        start_i = 1'b0;
      end
      if (rd_at_end && c == CONV - 1) result_rd_i = 1'b1;
      @(negedge clk);
      result_rd_i = 1'b0;
    end
    start_i = 1'b0;
    checks++;
    if (dac_bad != 0) fails++;
    chk("R8 channel held", chan_bad, 0);
    chk(inject ? "R7 busy length with ignored start" : "R2 busy length", busy_cnt, CONV);
    chk("R2 done at end", int'(done_o), 1);
    chk(inject ? "R7 result unaffected" : "R4 result", int'(result_o), code);
  endtask

  task automatic set_modes(input logic [1:0] m);
    @(negedge clk);
    mode_wr_i = 1'b1;
    mode_i    = m;
    @(negedge clk);
    mode_wr_i = 1'b0;
    mode_i    = ~m;
    chk("R9 mode load", int'(mode_o), int'(m));
  endtask

  task automatic pin_probe(input logic [1:0] p);
    pin_i = p;
    #1;
    chk("R9 pin read-back", int'(pin_rd_o), int'(p & ~mode_o));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; start_i = 1'b0; chan_i = '0; result_rd_i = 1'b0;
    mode_wr_i = 1'b0; mode_i = '0; pin_i = '0; vin0 = '0; vin1 = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 result", int'(result_o), 0);
    chk("R1 dac", int'(dac_code_o), 0);
    chk("R1 modes", int'(mode_o), 0);

    // R9 digital mode after reset: pins pass through
    pin_probe(2'b11);
    pin_probe(2'b10);

    // Directed corners for R4: zero, top, above scale, exact boundaries
    convert(0, 0,   1'b0, 1'b0);
    convert(1, 124, 1'b0, 1'b0);
    convert(0, 200, 1'b0, 1'b0);
    convert(1, 64,  1'b0, 1'b0);
    convert(0, 63,  1'b0, 1'b0);

    // R6 read strobe clears done; result stays
    @(negedge clk);
    result_rd_i = 1'b1;
    @(negedge clk);
    result_rd_i = 1'b0;
    chk("R6 done cleared by read", int'(done_o), 0);
    chk("R5 result kept after read", int'(result_o), exp_code(63));

    // R6 completion and read at the same edge: the flag stays set
    convert(1, 37, 1'b0, 1'b1);

    // R7/R8 start and channel change during a run are ignored
    convert(0, 90, 1'b1, 1'b0);
    convert(1, 5,  1'b1, 1'b0);

    // R9 per-pin mode selection
    set_modes(2'b01);
    pin_probe(2'b11);
    pin_probe(2'b10);
    set_modes(2'b10);
    pin_probe(2'b11);
    pin_probe(2'b01);
    set_modes(2'b11);
    pin_probe(2'b11);
    set_modes(2'b00);
    pin_probe(2'b11);

    // Random conversions
    for (int i = 0; i < 30; i++) begin
      convert(int'($urandom_range(1, 0)), int'($urandom_range(140, 0)),
              ($urandom_range(3, 0) == 0), 1'b0);
      if ($urandom_range(1, 0) == 1) begin
        set_modes(2'($urandom_range(3, 0)));
        pin_probe(2'($urandom_range(3, 0)));
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule